// File: doc/BRIEF.md
# Tile Seam Stitcher

The tiles of an image are first segmented independently. This block then joins the components that touch across the boundary between two neighbouring tiles. It walks along one seam and, at each position, pairs the pixel on the near side with the pixel directly facing it on the far side. Diagonal neighbours are not considered. It measures the colour distance between the two pixels and applies a threshold merge rule to the two components, which live in a shared union-find store. The store holds one record per vertex: a parent index, a component size and a component threshold. The block reads that record through a combinational read port and updates it through a single write port. Pixel colours come from a separate combinational read port.

Vertex indices are global, computed as row times image width plus column, so labels from different tiles never collide. A column seam pairs the last column of the left tile with the first column of the right tile. A row seam pairs the last row of the upper tile with the first row of the lower tile. The controlling logic issues one `start` per seam. It runs the column seams of each tile row first, then one row seam across the full width to join the resulting halves. `done` marks the end of each seam.

Top module: `seam_stitcher`

## Requirements
- R1: With `orient`=0 (column seam), pair i joins vertex (seam_first+i)*IMG_W + seam_pos-1 with vertex (seam_first+i)*IMG_W + seam_pos, for i from 0 to seam_len-1.
- R2: With `orient`=1 (row seam), pair i joins vertex (seam_pos-1)*IMG_W + seam_first+i with vertex seam_pos*IMG_W + seam_first+i.
- R3: The weight of a pair is the sum over the three channels of the absolute channel difference. A pixel word packs channel 0 in bits [3:0], channel 1 in [7:4] and channel 2 in [11:8].
- R4: Both vertices are resolved to their roots by following parent links until a record is its own parent. A pair whose two roots are equal causes no write.
- R5: Two distinct roots merge only when the weight is less than or equal to both root thresholds (equality merges). Otherwise no write happens.
- R6: A merge is two consecutive writes. First the child root is written with parent = surviving root and its own size and threshold unchanged. Then the surviving root is written with parent = itself, size = sum of both sizes, and threshold = weight + MERGE_K / summed size (integer division). The surviving root is the one with the larger size; on equal sizes the lower index survives.
- R7: Pairs are processed in increasing position along the seam, and all writes of one pair come before any write of the next.
- R8: `done` is high for exactly one cycle after the last pair. A seam of length 0 gives `done` with no writes. `start` is ignored while a seam is in progress.
- R9: During and right after synchronous reset, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one seam when idle |
| orient | input | 1 | 0 = column seam, 1 = row seam |
| seam_pos | input | COORD_W (3) | First column (or row) of the far tile |
| seam_first | input | COORD_W (3) | First position along the seam |
| seam_len | input | LEN_W (4) | Number of pairs on the seam |
| pix_addr | output | IDX_W (6) | Pixel read address |
| pix_data | input | PIX_W (12) | Pixel colour at pix_addr |
| rd_addr | output | IDX_W (6) | Vertex record read address |
| rd_parent | input | IDX_W (6) | Parent index of the record at rd_addr |
| rd_size | input | SIZE_W (8) | Size field of the record at rd_addr |
| rd_thr | input | THR_W (10) | Threshold field of the record at rd_addr |
| wr_en | output | 1 | Vertex record write strobe |
| wr_addr | output | IDX_W (6) | Vertex record write address |
| wr_parent | output | IDX_W (6) | Parent index to write |
| wr_size | output | SIZE_W (8) | Size to write |
| wr_thr | output | THR_W (10) | Threshold to write |
| done | output | 1 | One-cycle end-of-seam pulse |

## Verification
The first pattern is four pre-segmented 4x4 tiles with flat colours and slight checkerboard noise, stitched in the intended order (two column seams, then one full-width row seam). It separates seams that merge from a seam whose colour gap exceeds both thresholds. It also shows that later pairs of an already joined component are skipped. The second pattern starts from singleton vertices with a gradient and two hand-placed pairs whose weights sit exactly on the threshold and one above it. This pins the `<=` boundary and the tie-break on equal sizes. An overlapping column seam then forces multi-hop root resolution. A zero-length seam and a `start` pulse in the middle of a run show that an empty seam completes cleanly and that a second command cannot disturb a run in progress.

// File: rtl/seam_stitch_pkg.sv
package seam_stitch_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PIX_A,
        ST_PIX_B,
        ST_FIND_A,
        ST_FIND_B,
        ST_JUDGE,
        ST_WR_CHILD,
        ST_WR_ROOT,
        ST_NEXT,
        ST_DONE
    } stitch_state_e;

    typedef enum logic {
        SEAM_COLS = 1'b0,
        SEAM_ROWS = 1'b1
    } seam_orient_e;

endpackage

// File: rtl/seam_addr_gen.sv
module seam_addr_gen #(
    parameter int IMG_W   = 8,
    parameter int COORD_W = 3,
    parameter int LEN_W   = 4,
    parameter int IDX_W   = 6
) (
    input  logic               orient,
    input  logic [COORD_W-1:0] pos,
    input  logic [COORD_W-1:0] first,
    input  logic [LEN_W-1:0]   step,
    output logic [IDX_W-1:0]   near_idx,
    output logic [IDX_W-1:0]   far_idx
);
    import seam_stitch_pkg::*;

    localparam logic [IDX_W-1:0] ROW_PITCH = IDX_W'(IMG_W);

    logic [IDX_W-1:0] along;
    logic [IDX_W-1:0] pos_x;

    assign along = IDX_W'(first) + IDX_W'(step);
    assign pos_x = IDX_W'(pos);

    always_comb begin
        if (seam_orient_e'(orient) == SEAM_ROWS) begin
            near_idx = (pos_x - IDX_W'(1)) * ROW_PITCH + along;
            far_idx  = pos_x * ROW_PITCH + along;
        end else begin
            near_idx = along * ROW_PITCH + pos_x - IDX_W'(1);
            far_idx  = along * ROW_PITCH + pos_x;
        end
    end
endmodule

// File: rtl/seam_weight.sv
module seam_weight #(
    parameter int CH_W = 4,
    parameter int NCH  = 3,
    parameter int W_W  = 6
) (
    input  logic [CH_W*NCH-1:0] pix_a,
    input  logic [CH_W*NCH-1:0] pix_b,
    output logic [W_W-1:0]      weight
);
    logic [CH_W-1:0] gap [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [CH_W-1:0] ca, cb;
        assign ca     = pix_a[g*CH_W +: CH_W];
        assign cb     = pix_b[g*CH_W +: CH_W];
        assign gap[g] = (ca > cb) ? (ca - cb) : (cb - ca);
    end

    always_comb begin
        weight = '0;
        for (int c = 0; c < NCH; c++) begin
            weight = weight + W_W'(gap[c]);
        end
    end
endmodule

// File: rtl/seam_merge_rule.sv
module seam_merge_rule #(
    parameter int IDX_W   = 6,
    parameter int SIZE_W  = 8,
    parameter int THR_W   = 10,
    parameter int W_W     = 6,
    parameter int MERGE_K = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  root_a,
    input  logic [SIZE_W-1:0] size_a,
    input  logic [THR_W-1:0]  thr_a,
    input  logic [IDX_W-1:0]  root_b,
    input  logic [SIZE_W-1:0] size_b,
    input  logic [THR_W-1:0]  thr_b,
    input  logic [W_W-1:0]    weight,
    output logic              do_merge,
    output logic [IDX_W-1:0]  keep_idx,
    output logic [IDX_W-1:0]  child_idx,
    output logic [SIZE_W-1:0] child_size,
    output logic [THR_W-1:0]  child_thr,
    output logic [SIZE_W-1:0] sum_size,
    output logic [THR_W-1:0]  new_thr
);
    localparam logic [THR_W-1:0] K_VAL = THR_W'(MERGE_K);

    logic [THR_W-1:0] w_ext;
    logic             a_keeps;

    assign w_ext    = THR_W'(weight);
    assign do_merge = (root_a != root_b) && (w_ext <= thr_a) && (w_ext <= thr_b);
    assign a_keeps  = (size_a > size_b) || ((size_a == size_b) && (root_a < root_b));

    assign keep_idx   = a_keeps ? root_a : root_b;
    assign child_idx  = a_keeps ? root_b : root_a;
    assign child_size = a_keeps ? size_b : size_a;
    assign child_thr  = a_keeps ? thr_b  : thr_a;
    assign sum_size   = size_a + size_b;
    assign new_thr    = w_ext + K_VAL / THR_W'(sum_size);

    AST_SIZE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        do_merge |-> (sum_size > size_a) && (sum_size > size_b)) else $error("size wrap"); // R6

    AST_SURVIVOR_NOT_SMALLER: assert property (@(posedge clk) disable iff (rst)
        do_merge |-> (child_size <= (a_keeps ? size_a : size_b))) else $error("bad survivor"); // R6
endmodule

// File: rtl/seam_stitcher.sv
module seam_stitcher #(
    parameter int IMG_W   = 8,
    parameter int IMG_H   = 8,
    parameter int CH_W    = 4,
    parameter int NCH     = 3,
    parameter int SIZE_W  = 8,
    parameter int THR_W   = 10,
    parameter int MERGE_K = 64,
    localparam int NPIX    = IMG_W * IMG_H,
    localparam int IDX_W   = $clog2(NPIX),
    localparam int COORD_W = $clog2((IMG_W > IMG_H) ? IMG_W : IMG_H),
    localparam int LEN_W   = COORD_W + 1,
    localparam int PIX_W   = CH_W * NCH,
    localparam int W_W     = CH_W + $clog2(NCH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               orient,
    input  logic [COORD_W-1:0] seam_pos,
    input  logic [COORD_W-1:0] seam_first,
    input  logic [LEN_W-1:0]   seam_len,
    output logic [IDX_W-1:0]   pix_addr,
    input  logic [PIX_W-1:0]   pix_data,
    output logic [IDX_W-1:0]   rd_addr,
    input  logic [IDX_W-1:0]   rd_parent,
    input  logic [SIZE_W-1:0]  rd_size,
    input  logic [THR_W-1:0]   rd_thr,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_addr,
    output logic [IDX_W-1:0]   wr_parent,
    output logic [SIZE_W-1:0]  wr_size,
    output logic [THR_W-1:0]   wr_thr,
    output logic               done
);
    import seam_stitch_pkg::*;

    stitch_state_e      st;
    logic               orient_q;
    logic [COORD_W-1:0] pos_q, first_q;
    logic [LEN_W-1:0]   len_q, step;
    logic [PIX_W-1:0]   pix_a_q;
    logic [W_W-1:0]     w_q, w_now;
    logic [IDX_W-1:0]   cur;
    logic [IDX_W-1:0]   root_a, root_b;
    logic [SIZE_W-1:0]  size_a, size_b;
    logic [THR_W-1:0]   thr_a, thr_b;

    logic [IDX_W-1:0]   near_idx, far_idx;
    logic               do_merge;
    logic [IDX_W-1:0]   keep_idx, child_idx;
    logic [SIZE_W-1:0]  child_size, sum_size;
    logic [THR_W-1:0]   child_thr, new_thr;

    seam_addr_gen #(.IMG_W(IMG_W), .COORD_W(COORD_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_addr (
        .orient(orient_q), .pos(pos_q), .first(first_q), .step(step),
        .near_idx(near_idx), .far_idx(far_idx)
    );

    seam_weight #(.CH_W(CH_W), .NCH(NCH), .W_W(W_W)) u_weight (
        .pix_a(pix_a_q), .pix_b(pix_data), .weight(w_now)
    );

    seam_merge_rule #(.IDX_W(IDX_W), .SIZE_W(SIZE_W), .THR_W(THR_W), .W_W(W_W),
                      .MERGE_K(MERGE_K)) u_rule (
        .clk(clk), .rst(rst),
        .root_a(root_a), .size_a(size_a), .thr_a(thr_a),
        .root_b(root_b), .size_b(size_b), .thr_b(thr_b),
        .weight(w_q), .do_merge(do_merge), .keep_idx(keep_idx),
        .child_idx(child_idx), .child_size(child_size), .child_thr(child_thr),
        .sum_size(sum_size), .new_thr(new_thr)
    );

    assign pix_addr = (st == ST_PIX_A) ? near_idx : far_idx;
    assign rd_addr  = cur;
    assign done     = (st == ST_DONE);

    always_comb begin
        wr_en     = 1'b0;
        wr_addr   = child_idx;
        wr_parent = keep_idx;
        wr_size   = child_size;
        wr_thr    = child_thr;
        if (st == ST_WR_CHILD) begin
            wr_en = 1'b1;
        end else if (st == ST_WR_ROOT) begin
            wr_en   = 1'b1;
            wr_addr = keep_idx;
            wr_size = sum_size;
            wr_thr  = new_thr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            orient_q <= 1'b0;
            pos_q    <= '0;
            first_q  <= '0;
            len_q    <= '0;
            step     <= '0;
            pix_a_q  <= '0;
            w_q      <= '0;
            cur      <= '0;
            root_a   <= '0;
            root_b   <= '0;
            size_a   <= '0;
            size_b   <= '0;
            thr_a    <= '0;
            thr_b    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    orient_q <= orient;
                    pos_q    <= seam_pos;
                    first_q  <= seam_first;
                    len_q    <= seam_len;
                    step     <= '0;
                    st       <= (seam_len == '0) ? ST_DONE : ST_PIX_A;
                end
                ST_PIX_A: begin
                    pix_a_q <= pix_data;
                    st      <= ST_PIX_B;
                end
                ST_PIX_B: begin
                    w_q <= w_now;
                    cur <= near_idx;
                    st  <= ST_FIND_A;
                end
                ST_FIND_A: begin
                    if (rd_parent == cur) begin
                        root_a <= cur;
                        size_a <= rd_size;
                        thr_a  <= rd_thr;
                        cur    <= far_idx;
                        st     <= ST_FIND_B;
                    end else begin
                        cur <= rd_parent;
                    end
                end
                ST_FIND_B: begin
                    if (rd_parent == cur) begin
                        root_b <= cur;
                        size_b <= rd_size;
                        thr_b  <= rd_thr;
                        st     <= ST_JUDGE;
                    end else begin
                        cur <= rd_parent;
                    end
                end
                ST_JUDGE:    st <= do_merge ? ST_WR_CHILD : ST_NEXT;
                ST_WR_CHILD: st <= ST_WR_ROOT;
                ST_WR_ROOT:  st <= ST_NEXT;
                ST_NEXT: begin
                    if (step == len_q - LEN_W'(1)) begin
                        st <= ST_DONE;
                    end else begin
                        step <= step + LEN_W'(1);
                        st   <= ST_PIX_A;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R8

    AST_WRITES_PAIRED: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |=> wr_en) else $error("child write without root write"); // R6

    AST_ROOT_AFTER_CHILD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_parent == wr_addr) && (wr_addr == $past(wr_parent)))
        else $error("root write does not match child link"); // R6

    AST_WRITE_JUSTIFIED: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (root_a != root_b) && (THR_W'(w_q) <= thr_a) && (THR_W'(w_q) <= thr_b))
        else $error("write without passing merge test"); // R5

    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && st != ST_DONE) |-> (step < len_q)) else $error("step overrun"); // R7
endmodule

// File: tb/seam_stitcher_tb_top.sv
`timescale 1ns/1ps
module seam_stitcher_tb_top;
    localparam int W  = 8;
    localparam int H  = 8;
    localparam int N  = W * H;
    localparam int K  = 64;
    localparam int T0 = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        orient;
    logic [2:0]  seam_pos, seam_first;
    logic [3:0]  seam_len;
    logic [5:0]  pix_addr, rd_addr, rd_parent, wr_addr, wr_parent;
    logic [11:0] pix_data;
    logic [7:0]  rd_size, wr_size;
    logic [9:0]  rd_thr, wr_thr;
    logic        wr_en, done;

    always #10 clk = ~clk;

    logic [5:0]  par_m [N];
    logic [7:0]  siz_m [N];
    logic [9:0]  thr_m [N];
    logic [11:0] pix_m [N];
    int sh_par [N];
    int sh_siz [N];
    int sh_thr [N];

    typedef struct packed {
        logic [5:0] a;
        logic [5:0] p;
        logic [7:0] s;
        logic [9:0] t;
    } wr_item_t;
    wr_item_t exp_q [$];

    int total = 0;
    int bad   = 0;

    assign rd_parent = par_m[rd_addr];
    assign rd_size   = siz_m[rd_addr];
    assign rd_thr    = thr_m[rd_addr];
    assign pix_data  = pix_m[pix_addr];

    always @(posedge clk) begin
        if (wr_en) begin
            par_m[wr_addr] <= wr_parent;
            siz_m[wr_addr] <= wr_size;
            thr_m[wr_addr] <= wr_thr;
        end
    end

    seam_stitcher dut_i (
        .clk(clk), .rst(rst), .start(start), .orient(orient),
        .seam_pos(seam_pos), .seam_first(seam_first), .seam_len(seam_len),
        .pix_addr(pix_addr), .pix_data(pix_data),
        .rd_addr(rd_addr), .rd_parent(rd_parent), .rd_size(rd_size), .rd_thr(rd_thr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_parent(wr_parent),
        .wr_size(wr_size), .wr_thr(wr_thr), .done(done)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sh_find(int i);
        int v = i;
        while (sh_par[v] != v) v = sh_par[v];
        return v;
    endfunction

    function automatic int mem_find(int i);
        int v = i;
        for (int g = 0; g < N && int'(par_m[v]) != v; g++) v = par_m[v];
        return v;
    endfunction

    function automatic int pix_weight(logic [11:0] x, logic [11:0] y);
        int s = 0;
        for (int c = 0; c < 3; c++) begin
            int d = int'(x[c*4 +: 4]) - int'(y[c*4 +: 4]);
            s += (d < 0) ? -d : d;
        end
        return s;
    endfunction

    function automatic logic [11:0] rgb(int c0, int c1, int c2);
        return {4'(c2), 4'(c1), 4'(c0)};
    endfunction

    task automatic set_vertex(int i, int p, int s, int t, logic [11:0] px);
        par_m[i] = 6'(p);  sh_par[i] = p;
        siz_m[i] = 8'(s);  sh_siz[i] = s;
        thr_m[i] = 10'(t); sh_thr[i] = t;
        pix_m[i] = px;
    endtask

    // Reference: expected writes for one pair (R3 weight, R4 roots, R5 test, R6 update)
    task automatic model_pair(int a, int b);
        int w, ra, rb, keep, kid, sum, nt;
        w  = pix_weight(pix_m[a], pix_m[b]);
        ra = sh_find(a);
        rb = sh_find(b);
        if (ra != rb && w <= sh_thr[ra] && w <= sh_thr[rb]) begin
            if (sh_siz[ra] > sh_siz[rb] || (sh_siz[ra] == sh_siz[rb] && ra < rb)) begin
                keep = ra; kid = rb;
            end else begin
                keep = rb; kid = ra;
            end
            sum = sh_siz[ra] + sh_siz[rb];
            nt  = (w + K / sum) % 1024;
            exp_q.push_back('{a: 6'(kid), p: 6'(keep), s: 8'(sh_siz[kid]), t: 10'(sh_thr[kid])});
            exp_q.push_back('{a: 6'(keep), p: 6'(keep), s: 8'(sum), t: 10'(nt)});
            sh_par[kid]  = keep;
            sh_siz[keep] = sum;
            sh_thr[keep] = nt;
        end
    endtask

    // Driver: model expected writes in pair order (R1 R2 R7), then launch the seam
    task automatic run_seam(bit o, int pos, int first, int len, string tag, bit poke);
        int n, mism;
        for (int i = 0; i < len; i++) begin
            int a, b;
            if (!o) begin a = (first + i) * W + pos - 1; b = a + 1; end
            else    begin a = (pos - 1) * W + first + i; b = a + W; end
            model_pair(a, b);
        end
        @(negedge clk);
        orient = o; seam_pos = 3'(pos); seam_first = 3'(first); seam_len = 4'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            orient = ~o; seam_pos = 3'd1; seam_first = 3'd0; seam_len = 4'd1;
            start = 1'b1;   // R8: must be ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R8", {tag, " done seen"}, int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R8", {tag, " done one cycle"}, int'(done), 0);
        check(exp_q.size() == 0, "R6", {tag, " pending writes"}, exp_q.size(), 0);
        exp_q.delete();
        mism = 0;
        for (int i = 0; i < N; i++) begin
            if (int'(par_m[i]) != sh_par[i] || int'(siz_m[i]) != sh_siz[i] ||
                int'(thr_m[i]) != sh_thr[i]) mism++;
        end
        check(mism == 0, tag, "store mismatches", mism, 0);
    endtask

    // Monitor: pop expected writes and compare as the design issues them (R6 R7)
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected write addr", int'(wr_addr), -1);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                check({wr_addr, wr_parent, wr_size, wr_thr} == e, "R6 R7", "write word",
                      int'({wr_addr, wr_parent, wr_size, wr_thr}), int'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; orient = 1'b0;
        seam_pos = '0; seam_first = '0; seam_len = '0;
        for (int i = 0; i < N; i++) set_vertex(i, i, 1, T0, '0);
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R9", "done in reset", int'(done), 0);
        check(wr_en == 1'b0, "R9", "wr_en in reset", int'(wr_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && wr_en == 1'b0, "R9", "idle after reset", int'({done, wr_en}), 0);

        // Scenario 1: four pre-segmented 4x4 tiles
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                int i, root, nz;
                logic [11:0] px;
                i    = r * W + c;
                root = (r / 4) * 4 * W + (c / 4) * 4;
                nz   = (r + c) % 2;
                if (r < 4 && c < 4)      px = rgb(5 + nz, 5, 5);
                else if (r < 4)          px = rgb(6 + nz, 5, 5);
                else if (c < 4)          px = rgb(5 + nz, 6, 5);
                else                     px = rgb(0 + nz, 15, 15);
                set_vertex(i, root, (i == root) ? 16 : 1, T0, px);
            end
        end
        run_seam(1'b0, 4, 0, 4, "R1", 1'b0);   // top tiles, column seam
        check(mem_find(0) == mem_find(4), "R1", "top tiles joined", mem_find(4), mem_find(0));
        run_seam(1'b0, 4, 4, 4, "R1 R5", 1'b0); // bottom tiles: gap too large
        check(mem_find(32) != mem_find(36), "R5", "bottom tiles apart", mem_find(36), -1);
        run_seam(1'b1, 4, 0, 8, "R2 R4", 1'b1); // row seam, start poked mid-run
        check(mem_find(0) == mem_find(32), "R2", "left halves joined", mem_find(32), mem_find(0));
        check(mem_find(0) != mem_find(36), "R5", "lower right stays apart", mem_find(36), -1);

        // Scenario 2: singleton vertices, threshold boundary and chained roots
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                set_vertex(r * W + c, r * W + c, 1, T0, rgb(r % 4, c % 4, (r * 3 + c) % 4));
            end
        end
        pix_m[2 * W + 2] = rgb(10, 0, 0);   // weight 20 = threshold: merges
        pix_m[3 * W + 2] = rgb(0, 10, 0);
        pix_m[2 * W + 3] = rgb(10, 0, 0);   // weight 21: stays apart
        pix_m[3 * W + 3] = rgb(0, 11, 0);
        run_seam(1'b1, 3, 2, 4, "R2 R3", 1'b0);
        check(mem_find(18) == mem_find(26), "R3", "weight equal to threshold merges",
              mem_find(26), mem_find(18));
        check(int'(par_m[26]) == 18, "R6", "tie keeps lower index", int'(par_m[26]), 18);
        check(mem_find(19) != mem_find(27), "R5", "weight above threshold apart", mem_find(27), -1);
        run_seam(1'b0, 3, 1, 4, "R1 R4", 1'b0);

        // Zero-length seam
        run_seam(1'b0, 2, 0, 0, "R8", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule